// File: doc/BRIEF.md
# Turn-Model Adaptive Mesh Routing Unit

This unit decides the output port for a head flit in one router of a two-dimensional mesh with no wraparound links. It compares the router's own coordinates with the flit's destination. It then names one of five ports: East, West, North, South, or Local for delivery at this node.

A two-bit policy select picks between two kinds of routing. The first is fixed dimension-order routing, which goes along X and then along Y. The other three are partially adaptive turn-restricted policies: west-leading, north-trailing and negative-leading. Each of those policies bans only two of the eight right-angle turns, so no cycle of channel dependencies can form. When a policy leaves two legal directions that both move the flit closer, four per-direction congestion flags decide between them.

The result is registered. A valid strobe comes with it one clock after a head-valid input. X grows toward East and Y grows toward North.

Top module: `turn_route_unit`

## Requirements
- R1: When the current coordinates equal the destination in both X and Y, the port is Local (code 0), in every policy and whatever the congestion flags are.
- R2: Policy 0 (dimension order) sends the flit East (1) or West (2) while the X coordinates differ. Once X matches, it sends the flit North (3) or South (4). Congestion flags have no effect in this policy.
- R3: Policy 1 (west-leading) returns West whenever the destination lies to the west. When the destination does not lie to the west, this policy never returns West.
- R4: Policy 2 (north-trailing) returns North only when the X coordinates already match and the destination lies to the north. If X still differs and the destination is to the north, it returns the X direction.
- R5: Policy 3 (negative-leading) returns West or South whenever the destination lies to the west or to the south. A positive hop (East or North) comes only when no negative hop remains.
- R6: When a policy allows two productive directions, the unit picks the one whose congestion flag is clear while the other flag is set. When both flags are equal, it picks the X direction. Congestion bit 0 belongs to East, bit 1 to West, bit 2 to North and bit 3 to South.
- R7: The unit only ever returns a productive port. It never returns East unless the destination X is larger, never West unless it is smaller, never North unless the destination Y is larger, and never South unless it is smaller.
- R8: The port and its valid flag appear on the clock edge after the edge that samples a head-valid input. The valid flag is high for exactly one cycle for each head. While no head is offered, the port output holds its last value.
- R9: During reset the valid flag is low and the port reads Local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld_i | input | 1 | A head flit's coordinates are offered this cycle |
| cur_x_i | input | CW | X coordinate of this router |
| cur_y_i | input | CW | Y coordinate of this router |
| dst_x_i | input | CW | Destination X coordinate |
| dst_y_i | input | CW | Destination Y coordinate |
| mode_i | input | 2 | Policy: 0 dimension order, 1 west-leading, 2 north-trailing, 3 negative-leading |
| cong_i | input | 4 | Congestion flags: bit 0 East, bit 1 West, bit 2 North, bit 3 South |
| port_o | output | 3 | Chosen port: 0 Local, 1 East, 2 West, 3 North, 4 South |
| port_vld_o | output | 1 | The port output is fresh for the head sampled one edge earlier |

## Verification
Every routing result is due exactly one clock edge after the edge that samples the head. The bench changes inputs on a falling edge and lets one rising edge capture them. It reads port_o and port_vld_o on the next falling edge, half a period after the register updates. For the hold check, no head is offered for two further cycles, and on each falling edge the bench confirms that the port is unchanged and the valid flag is low. The reset values are read while reset is still asserted.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    MODE_DOR = 2'd0,
    MODE_WLD = 2'd1,
    MODE_NTR = 2'd2,
    MODE_NLD = 2'd3
  } mode_e;

  localparam int unsigned NUM_DIRS  = 4;
  localparam int unsigned NUM_PORTS = NUM_DIRS + 1;

endpackage

// File: rtl/rt_offset_decode.sv
module rt_offset_decode #(
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic          go_e_o,
  output logic          go_w_o,
  output logic          go_n_o,
  output logic          go_s_o
);

  always_comb begin
    go_e_o = (dst_x_i > cur_x_i);
    go_w_o = (dst_x_i < cur_x_i);
    go_n_o = (dst_y_i > cur_y_i);
    go_s_o = (dst_y_i < cur_y_i);
  end

endmodule

// File: rtl/rt_turn_policy.sv
module rt_turn_policy
  import rt_pkg::*;
(
  input  logic  go_e_i,
  input  logic  go_w_i,
  input  logic  go_n_i,
  input  logic  go_s_i,
  input  mode_e mode_i,
  output port_e first_o,
  output port_e second_o,
  output logic  choice_o
);

  port_e x_dir;
  port_e y_dir;
  logic  x_any;
  logic  y_any;

  always_comb begin
    x_dir = go_e_i ? PORT_EAST  : (go_w_i ? PORT_WEST  : PORT_LOCAL);
    y_dir = go_n_i ? PORT_NORTH : (go_s_i ? PORT_SOUTH : PORT_LOCAL);
    x_any = go_e_i | go_w_i;
    y_any = go_n_i | go_s_i;
  end

  always_comb begin
    // Default: dimension order, X before Y, no alternative.
    first_o  = x_any ? x_dir : y_dir;
    second_o = first_o;
    choice_o = 1'b0;
    unique case (mode_i)
      MODE_DOR: ;
      MODE_WLD: begin
        if (go_w_i) begin
          first_o  = PORT_WEST;
          second_o = PORT_WEST;
        end else if (go_e_i && y_any) begin
          first_o  = PORT_EAST;
          second_o = y_dir;
          choice_o = 1'b1;
        end
      end
      MODE_NTR: begin
        if (go_s_i && x_any) begin
          first_o  = x_dir;
          second_o = PORT_SOUTH;
          choice_o = 1'b1;
        end
      end
      MODE_NLD: begin
        if (go_w_i && go_s_i) begin
          first_o  = PORT_WEST;
          second_o = PORT_SOUTH;
          choice_o = 1'b1;
        end else if (go_e_i && go_s_i) begin
          first_o  = PORT_SOUTH;
          second_o = PORT_SOUTH;
        end else if (go_e_i && go_n_i) begin
          first_o  = PORT_EAST;
          second_o = PORT_NORTH;
          choice_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rt_cong_pick.sv
module rt_cong_pick
  import rt_pkg::*;
(
  input  port_e                first_i,
  input  port_e                second_i,
  input  logic                 choice_i,
  input  logic [NUM_DIRS-1:0]  cong_i,
  output port_e                pick_o
);

  logic [NUM_PORTS-1:0] busy_by_port;

  assign busy_by_port[0] = 1'b0;
  for (genvar g = 1; g < NUM_PORTS; g++) begin : g_busy
    assign busy_by_port[g] = cong_i[g-1];
  end

  logic first_busy;
  logic second_busy;

  always_comb begin
    first_busy  = busy_by_port[first_i];
    second_busy = busy_by_port[second_i];
    pick_o      = first_i;
    if (choice_i && first_busy && !second_busy) begin
      pick_o = second_i;
    end
  end

endmodule

// File: rtl/turn_route_unit.sv
module turn_route_unit
  import rt_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_vld_i,
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [1:0]    mode_i,
  input  logic [3:0]    cong_i,
  output logic [2:0]    port_o,
  output logic          port_vld_o
);

  logic  go_e, go_w, go_n, go_s;
  port_e first_dir, second_dir, pick;
  logic  has_choice;

  rt_offset_decode #(.CW(CW)) dec_i (
    .cur_x_i (cur_x_i),
    .cur_y_i (cur_y_i),
    .dst_x_i (dst_x_i),
    .dst_y_i (dst_y_i),
    .go_e_o  (go_e),
    .go_w_o  (go_w),
    .go_n_o  (go_n),
    .go_s_o  (go_s)
  );

  rt_turn_policy pol_i (
    .go_e_i   (go_e),
    .go_w_i   (go_w),
    .go_n_i   (go_n),
    .go_s_i   (go_s),
    .mode_i   (mode_e'(mode_i)),
    .first_o  (first_dir),
    .second_o (second_dir),
    .choice_o (has_choice)
  );

  rt_cong_pick pick_i (
    .first_i  (first_dir),
    .second_i (second_dir),
    .choice_i (has_choice),
    .cong_i   (cong_i),
    .pick_o   (pick)
  );

  port_e port_q, port_d;
  logic  vld_q, vld_d;
  logic  port_en;

  always_comb begin
    port_en = head_vld_i;
    port_d  = pick;
    vld_d   = head_vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= PORT_LOCAL;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (port_en) begin
        port_q <= port_d;
      end
    end
  end

  assign port_o     = port_q;
  assign port_vld_o = vld_q;

endmodule

// File: rtl/rt_route_chk.sv
module rt_route_chk
  import rt_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_vld_i,
  input logic [CW-1:0] cur_x_i,
  input logic [CW-1:0] cur_y_i,
  input logic [CW-1:0] dst_x_i,
  input logic [CW-1:0] dst_y_i,
  input logic [1:0]    mode_i,
  input logic [2:0]    port_o,
  input logic          port_vld_o
);

  assert_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && cur_x_i == dst_x_i && cur_y_i == dst_y_i |=> port_o == PORT_LOCAL);

  assert_dor_x_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && mode_i == MODE_DOR && cur_x_i != dst_x_i
    |=> (port_o == PORT_EAST || port_o == PORT_WEST));

  assert_wld_no_late_west_R3: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && mode_i == MODE_WLD && dst_x_i >= cur_x_i |=> port_o != PORT_WEST);

  assert_ntr_north_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && mode_i == MODE_NTR && cur_x_i != dst_x_i |=> port_o != PORT_NORTH);

  assert_nld_neg_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && mode_i == MODE_NLD && (dst_x_i < cur_x_i || dst_y_i < cur_y_i)
    |=> (port_o == PORT_WEST || port_o == PORT_SOUTH));

  assert_no_east_R7: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && dst_x_i <= cur_x_i |=> port_o != PORT_EAST);

  assert_no_north_R7: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i && dst_y_i <= cur_y_i |=> port_o != PORT_NORTH);

  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    head_vld_i |=> port_vld_o);

  assert_vld_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld_i |=> !port_vld_o);

  assert_port_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !head_vld_i |=> $stable(port_o));

  always_comb begin
    if (!rst_n) begin
      assert_reset_R9: assert (port_vld_o == 1'b0 && port_o == PORT_LOCAL);
    end
  end

endmodule

bind turn_route_unit rt_route_chk #(.CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .head_vld_i (head_vld_i),
  .cur_x_i    (cur_x_i),
  .cur_y_i    (cur_y_i),
  .dst_x_i    (dst_x_i),
  .dst_y_i    (dst_y_i),
  .mode_i     (mode_i),
  .port_o     (port_o),
  .port_vld_o (port_vld_o)
);

// File: tb/turn_route_unit_tb_top.sv
`timescale 1ns/1ps
module turn_route_unit_tb_top;

  localparam int CW = 4;
  localparam logic [2:0] P_L = 3'd0, P_E = 3'd1, P_W = 3'd2, P_N = 3'd3, P_S = 3'd4;
  localparam logic [1:0] M_DOR = 2'd0, M_WLD = 2'd1, M_NTR = 2'd2, M_NLD = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          head_vld;
  logic [CW-1:0] cx, cy, dx, dy;
  logic [1:0]    mode;
  logic [3:0]    cong;
  logic [2:0]    port;
  logic          pvld;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  turn_route_unit #(.CW(CW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_vld_i (head_vld),
    .cur_x_i    (cx),
    .cur_y_i    (cy),
    .dst_x_i    (dx),
    .dst_y_i    (dy),
    .mode_i     (mode),
    .cong_i     (cong),
    .port_o     (port),
    .port_vld_o (pvld)
  );

  task automatic check(input string tag, input logic [2:0] act_p, input logic [2:0] exp_p,
                       input logic act_v, input logic exp_v);
    checks++;
    if (act_p !== exp_p || act_v !== exp_v) begin
      failures++;
      $display("FAIL %s: port=%0d vld=%0b expected port=%0d vld=%0b",
               tag, act_p, act_v, exp_p, exp_v);
    end
  endtask

  // Offer one head on a falling edge; result is read one rising edge later.
  task automatic route(input string tag, input logic [1:0] m,
                       input logic [3:0] c_x, input logic [3:0] c_y,
                       input logic [3:0] d_x, input logic [3:0] d_y,
                       input logic [3:0] cg, input logic [2:0] exp_p);
    @(negedge clk);
    head_vld = 1'b1; mode = m; cx = c_x; cy = c_y; dx = d_x; dy = d_y; cong = cg;
    @(negedge clk);
    check(tag, port, exp_p, pvld, 1'b1);
    head_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset", port, P_L, pvld, 1'b0);
  endtask

  task automatic t_local();
    route("R1 local dor", M_DOR, 4, 4, 4, 4, 4'b1111, P_L);
    route("R1 local wld", M_WLD, 4, 4, 4, 4, 4'b1111, P_L);
    route("R1 local ntr", M_NTR, 4, 4, 4, 4, 4'b1111, P_L);
    route("R1 local nld", M_NLD, 4, 4, 4, 4, 4'b0000, P_L);
  endtask

  task automatic t_dor();
    route("R2 dor east despite congestion", M_DOR, 2, 2, 5, 1, 4'b0001, P_E);
    route("R2 dor west first",              M_DOR, 2, 2, 0, 4, 4'b0010, P_W);
    route("R2 dor north after X",           M_DOR, 2, 2, 2, 5, 4'b0100, P_N);
    route("R2 dor south after X",           M_DOR, 2, 2, 2, 0, 4'b1000, P_S);
  endtask

  task automatic t_wld();
    route("R3 wld west while congested",   M_WLD, 3, 3, 1, 5, 4'b0010, P_W);
    route("R3 R6 wld tie picks X",         M_WLD, 3, 3, 5, 5, 4'b0000, P_E);
    route("R3 R6 wld east busy -> north",  M_WLD, 3, 3, 5, 5, 4'b0001, P_N);
    route("R6 wld both busy picks X",      M_WLD, 3, 3, 5, 5, 4'b0101, P_E);
    route("R3 R7 wld south only",          M_WLD, 3, 3, 3, 1, 4'b1011, P_S);
  endtask

  task automatic t_ntr();
    route("R4 ntr X before north",         M_NTR, 3, 3, 5, 6, 4'b0001, P_E);
    route("R4 ntr north last",             M_NTR, 3, 3, 3, 6, 4'b0100, P_N);
    route("R4 R6 ntr west busy -> south",  M_NTR, 3, 3, 1, 0, 4'b0010, P_S);
    route("R4 R6 ntr tie picks west",      M_NTR, 3, 3, 1, 0, 4'b0000, P_W);
  endtask

  task automatic t_nld();
    route("R5 nld west before north",      M_NLD, 3, 3, 1, 6, 4'b0010, P_W);
    route("R5 nld south before east",      M_NLD, 3, 3, 6, 1, 4'b1000, P_S);
    route("R5 R6 nld west busy -> south",  M_NLD, 3, 3, 1, 1, 4'b0010, P_S);
    route("R5 R6 nld east busy -> north",  M_NLD, 3, 3, 6, 6, 4'b0001, P_N);
    route("R5 R6 nld tie picks east",      M_NLD, 3, 3, 6, 6, 4'b0000, P_E);
  endtask

  task automatic t_hold();
    route("R8 hold setup", M_DOR, 1, 1, 7, 1, 4'b0000, P_E);
    mode = M_NLD; cx = 5; cy = 5; dx = 0; dy = 0; cong = 4'b1111;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check("R8 hold without head", port, P_E, pvld, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0; head_vld = 1'b0; mode = '0; cx = '0; cy = '0; dx = '0; dy = '0; cong = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_local();
    t_dor();
    t_wld();
    t_ntr();
    t_nld();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule